// File: doc/BRIEF.md
# Transmit Minimum-Frame Padder

This block sits on the transmit path just ahead of a MAC that appends the 4-byte frame check sequence on its own but sends short frames as they are. Upstream logic delivers frames made of header and payload only, as a byte stream on a bus that is 64 bytes wide. Byte 0 of the frame is on bits [7:0], the next byte is on [15:8], and so on. Each beat carries data, a per-byte keep mask, a last marker and a valid/ready handshake.

A frame shorter than the minimum pre-FCS length (60 bytes by default) always arrives as one beat that is both the first and the last beat of its frame. The block extends that beat's keep mask to cover lanes 0 to MIN_LEN-1 and puts zero bytes in every lane it adds, so the frame plus the appended FCS reaches 64 bytes. No cycle is added. All other beats pass through untouched. The block tracks whether the next beat starts a frame. The handshake passes straight through, so the block adds no latency and loses no data under backpressure.

Top module: `tx_min_frame_pad`

## Requirements
- R1: out_valid always equals in_valid and in_ready always equals out_ready, in the same cycle, with no added latency.
- R2: After reset, the next beat presented is treated as the first beat of a frame, even if reset interrupted a frame in progress.
- R3: A beat that starts a frame and has in_last high, with fewer than MIN_LEN set keep bits, leaves with out_keep bits 0 to MIN_LEN-1 all set, together with its original keep bits.
- R4: Every lane that R3 adds to the keep mask carries the byte value zero on out_data.
- R5: On a padded beat, lanes whose in_keep bit was set keep their input byte and keep bit. Lanes at or above MIN_LEN are passed through unchanged.
- R6: A single-beat frame with MIN_LEN or more set keep bits passes through with out_data and out_keep equal to the inputs.
- R7: Every beat of a multi-beat frame passes through unchanged, including a short final beat.
- R8: The frame-start state changes only on an accepted beat (valid and ready both high). It becomes "start" after an accepted last beat and "not start" after an accepted non-last beat. A stalled beat leaves it as it was.
- R9: out_last always equals in_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8*BYTES | Upstream frame bytes, lane 0 on bits [7:0] |
| in_keep | input | BYTES | Upstream byte-valid mask |
| in_last | input | 1 | Upstream final beat of frame |
| in_valid | input | 1 | Upstream beat present |
| in_ready | output | 1 | Block can take the beat |
| out_data | output | 8*BYTES | Frame bytes toward the MAC, padding zeroed |
| out_keep | output | BYTES | Byte-valid mask toward the MAC |
| out_last | output | 1 | Final beat of frame toward the MAC |
| out_valid | output | 1 | Beat present toward the MAC |
| out_ready | input | 1 | MAC can take the beat |

## Verification
The hardest case to reach from the ports is a short beat that ends a multi-beat frame. It looks exactly like a short single-beat frame, and only the frame-start state separates the two. The stimulus therefore sends two- and three-beat frames whose final beat takes every length from 1 to BYTES. It holds a non-last beat stalled for several cycles before it is accepted, and it resets in the middle of a frame before a short frame follows. A small bus (8 lanes, minimum 6) allows a full sweep of every keep length in every position.

// File: rtl/pad_pkg.sv
`timescale 1ns/1ps
package pad_pkg;
  localparam int unsigned LANE_BITS = 8;

  // A lane lies inside the minimum-length region when its index is below the floor.
  function automatic logic lane_in_floor(int unsigned lane, int unsigned floor_len);
    return lane < floor_len;
  endfunction

  // Lane is added by padding: inside the floor and not already carried.
  function automatic logic lane_added(logic fill_en, logic in_floor, logic kept);
    return fill_en & in_floor & ~kept;
  endfunction
endpackage

// File: rtl/pad_frame_tracker.sv
`timescale 1ns/1ps
module pad_frame_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_fire,
  input  logic beat_last,
  output logic at_start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         at_start <= 1'b1;
    else if (beat_fire) at_start <= beat_last;
  end
endmodule

// File: rtl/pad_lane_fill.sv
`timescale 1ns/1ps
module pad_lane_fill #(
  parameter int unsigned BYTES   = 64,
  parameter int unsigned MIN_LEN = 60,
  localparam int unsigned DW     = BYTES * pad_pkg::LANE_BITS
) (
  input  logic [DW-1:0]    data_i,
  input  logic [BYTES-1:0] keep_i,
  input  logic             fill_en,
  output logic [DW-1:0]    data_o,
  output logic [BYTES-1:0] keep_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    localparam logic IN_FLOOR = pad_pkg::lane_in_floor(b, MIN_LEN);
    logic add;
    assign add = pad_pkg::lane_added(fill_en, IN_FLOOR, keep_i[b]);
    assign keep_o[b] = keep_i[b] | add;
    assign data_o[b*8 +: 8] = add ? 8'h00 : data_i[b*8 +: 8];
  end
endmodule

// File: rtl/tx_min_frame_pad.sv
`timescale 1ns/1ps
module tx_min_frame_pad #(
  parameter int unsigned BYTES   = 64,
  parameter int unsigned MIN_LEN = 60,
  localparam int unsigned DW     = BYTES * pad_pkg::LANE_BITS,
  localparam int unsigned CNT_W  = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    in_data,
  input  logic [BYTES-1:0] in_keep,
  input  logic             in_last,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [DW-1:0]    out_data,
  output logic [BYTES-1:0] out_keep,
  output logic             out_last,
  output logic             out_valid,
  input  logic             out_ready
);
  logic             beat_fire;
  logic             at_start;
  logic             pad_evt;
  logic [CNT_W-1:0] kept_lanes;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_last  = in_last;
  assign beat_fire = in_valid & out_ready;

  always_comb begin
    kept_lanes = '0;
    for (int i = 0; i < BYTES; i++) kept_lanes = kept_lanes + CNT_W'(in_keep[i]);
  end

  assign pad_evt = at_start & in_last & (kept_lanes < CNT_W'(MIN_LEN));

  pad_frame_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_fire (beat_fire),
    .beat_last (in_last),
    .at_start  (at_start)
  );

  pad_lane_fill #(.BYTES(BYTES), .MIN_LEN(MIN_LEN)) u_fill (
    .data_i  (in_data),
    .keep_i  (in_keep),
    .fill_en (pad_evt),
    .data_o  (out_data),
    .keep_o  (out_keep)
  );
endmodule

// File: rtl/pad_checker.sv
`timescale 1ns/1ps
module pad_checker #(
  parameter int unsigned BYTES   = 64,
  parameter int unsigned MIN_LEN = 60,
  localparam int unsigned DW     = BYTES * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DW-1:0]    in_data,
  input logic [BYTES-1:0] in_keep,
  input logic             in_last,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DW-1:0]    out_data,
  input logic [BYTES-1:0] out_keep,
  input logic             out_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic             at_start
);
  logic [BYTES-1:0] fill_bad;
  for (genvar b = 0; b < BYTES; b++) begin : g_chk
    assign fill_bad[b] = out_keep[b] & ~in_keep[b] & (|out_data[b*8 +: 8]);
  end

  AST_VALID_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == in_valid); // R1
  AST_READY_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == out_ready); // R1
  AST_PAD_REACHES_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_keep != in_keep) |-> (&out_keep[MIN_LEN-1:0])); // R3
  AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> fill_bad == '0); // R4
  AST_KEEP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_keep & in_keep) == in_keep); // R5
  AST_LONG_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && $countones(in_keep) >= MIN_LEN) |->
      (out_keep == in_keep && out_data == in_data)); // R6
  AST_MID_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_last) |=>
      (!in_valid || (out_keep == in_keep && out_data == in_data))); // R7
  AST_START_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> at_start); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(at_start)); // R8
  AST_LAST_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    out_last == in_last); // R9
endmodule

bind tx_min_frame_pad pad_checker #(.BYTES(BYTES), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_keep(in_keep),
  .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
  .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
  .out_valid(out_valid), .out_ready(out_ready), .at_start(at_start)
);

// File: tb/sim_tx_min_frame_pad.sv
`timescale 1ns/1ps
module sim_tx_min_frame_pad;
  localparam int NB = 8;
  localparam int ML = 6;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [NB-1:0] in_keep = '0;
  logic          in_last = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] out_data;
  logic [NB-1:0] out_keep;
  logic          out_last;
  logic          out_valid;
  logic          out_ready = 1'b0;

  int  checks = 0;
  int  errors = 0;
  bit  exp_start = 1'b1;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  tx_min_frame_pad #(.BYTES(NB), .MIN_LEN(ML)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_keep(in_keep),
    .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [NB-1:0] k);
    int c = 0;
    for (int i = 0; i < NB; i++) c += int'(k[i]);
    return c;
  endfunction

  // Check all outputs for the beat currently on the inputs.
  task automatic check_beat(input string req);
    logic [NB-1:0] ek;
    logic [DW-1:0] ed;
    bit pad;
    pad = exp_start && in_last && (ones(in_keep) < ML);
    ek = pad ? (in_keep | NB'((1 << ML) - 1)) : in_keep;
    ed = in_data;
    for (int i = 0; i < NB; i++)
      if (ek[i] && !in_keep[i]) ed[i*8 +: 8] = 8'h00;
    chk({req, " keep"}, DW'(out_keep), DW'(ek));
    chk({req, " data"}, out_data, ed);
    chk("R9 last", DW'(out_last), DW'(in_last));
    chk("R1 valid", DW'(out_valid), DW'(in_valid));
    chk("R1 ready", DW'(in_ready), DW'(out_ready));
  endtask

  task automatic send(input int n, input bit last, input int stall, input string req);
    @(negedge clk);
    in_valid  = 1'b1;
    in_keep   = NB'((1 << n) - 1);
    in_last   = last;
    in_data   = {$urandom, $urandom};
    out_ready = 1'b0;
    for (int s = 0; s < stall; s++) begin
      #1 check_beat({req, " stalled"});
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1 check_beat(req);
    @(posedge clk);
    exp_start = last;
    #1 in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R2 reset valid", DW'(out_valid), '0);
    chk("R1 reset ready", DW'(in_ready), DW'(1));
    @(negedge clk) rst_n = 1'b1;

    // R2: the first beat after reset is a frame start, so it gets padded.
    send(1, 1'b1, 0, "R2 first after reset");
    // R3 R4 R5 R6: single-beat frames of every length.
    for (int n = 1; n <= NB; n++) send(n, 1'b1, 0, n < ML ? "R3 R4 R5 short single" : "R6 long single");
    // R7: two-beat frames whose tail has every length.
    for (int n = 1; n <= NB; n++) begin
      send(NB, 1'b0, 0, "R7 head");
      send(n, 1'b1, 0, "R7 short tail");
      send(2, 1'b1, 0, "R3 after multi");
    end
    // R7: three-beat frames.
    for (int n = 1; n <= NB; n++) begin
      send(NB, 1'b0, 0, "R7 head");
      send(NB, 1'b0, 0, "R7 middle");
      send(n, 1'b1, 0, "R7 tail");
    end
    // R8: stalled beats keep the frame-start state.
    for (int st = 1; st <= 3; st++) begin
      send(3, 1'b1, st, "R8 R3 stalled short single");
      send(NB, 1'b0, st, "R8 stalled head");
      send(2, 1'b1, st, "R8 R7 stalled short tail");
    end
    // R2: a reset in the middle of a frame restarts framing.
    send(NB, 1'b0, 0, "R7 head before reset");
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    exp_start = 1'b1;
    send(2, 1'b1, 0, "R2 short after mid-frame reset");

    @(negedge clk);
    #1 chk("R1 idle valid", DW'(out_valid), '0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule